// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer descriptors held in system memory. Each table entry describes one receive buffer with a 32-bit base address and a 32-bit word count. On each fetch request the block reads the entry at its current read pointer through a simple memory read port. It presents the buffer base and word count as outputs, then moves the read pointer to the next entry. The pointer wraps back to the ring start when it lands exactly on the ring end.

Software places entries in the ring and programs several inputs: the ring start, the ring end, the software write pointer, and a shared upper address half. The block raises an exhausted flag when the advanced read pointer lands on the write pointer. While that flag is set, the receive path must refuse incoming frames. Clearing the flag restarts fetching on its own. Fetch requests that arrive during a fetch are counted and serviced one after another. Only one memory read is ever in flight.

Top module: `rrf_ring_fetch`

## Requirements
- R1: After reset the read pointer, buffer base, buffer word count, exhausted flag, busy flag and memory request are all zero.
- R2: A fetch issues four single reads in field order 0 to 3: base low, base high, count low, count high. The address of each read is {upper, read pointer + field x slot}, where the slot is 2 bytes in narrow mode and 4 bytes in wide mode. A new request is issued only after the previous read's data-valid, so mem_req is never high in two consecutive cycles.
- R3: When the fourth read returns, buf_base becomes {field1, field0} and buf_words becomes {field3, field2}.
- R4: Each field is taken from mem_rdata[15:0], except in wide mode with big-endian selected, where it is taken from mem_rdata[31:16].
- R5: On completion the read pointer advances by 8 in narrow mode and by 16 in wide mode.
- R6: If the advanced pointer equals the ring end, the read pointer is reloaded with the ring start.
- R7: If the pointer after advance and wrap equals the write pointer, the exhausted flag is set at completion. A set takes precedence over a clear in the same cycle.
- R8: Pulsing exh_clr while the flag is set clears the flag and queues one new fetch. Pulsing it while the flag is clear changes nothing: busy stays low and no memory request follows.
- R9: Bit 0 of the ring start, ring end, write pointer and loaded read pointer is treated as zero.
- R10: busy is high from the cycle after a fetch request until the last queued fetch completes. Requests made during a fetch are serviced in order, each starting from the pointer left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_wide | input | 1 | 1: each field sits in a 32-bit slot |
| cfg_big_endian | input | 1 | selects the upper half of a wide slot |
| cfg_upper | input | 16 | upper address half shared by all ring addresses |
| cfg_ring_start | input | 16 | ring start pointer |
| cfg_ring_end | input | 16 | ring end pointer (one past last entry) |
| cfg_wr_ptr | input | 16 | software write pointer |
| rd_load | input | 1 | load the read pointer from rd_load_val |
| rd_load_val | input | 16 | new read pointer value |
| fetch_cmd | input | 1 | request one entry fetch |
| exh_clr | input | 1 | write-one-to-clear of the exhausted flag |
| mem_req | output | 1 | memory read request, one cycle |
| mem_addr | output | 32 | memory byte address of the read |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | 32 | read data |
| busy | output | 1 | a fetch is active or queued |
| rd_ptr | output | 16 | current read pointer |
| buf_base | output | 32 | buffer base address from the last entry |
| buf_words | output | 32 | buffer word count from the last entry |
| exhausted | output | 1 | resources exhausted; reception refused |

## Verification
The memory image returns, at each address, a word derived from that address with different upper and lower halves. A wrong lane choice, field order or read address therefore shows up directly in buf_base and buf_words. Fetches run in narrow mode, wide little-endian mode and wide big-endian mode, with varying read latency. These runs separate the slot size, lane choice and step size. The ring is placed so that one fetch lands on the write pointer and a later one lands on the ring end. A clear of the exhausted flag while it is set is contrasted with one while it is clear. A burst of requests issued during an active fetch tests in-order queuing, and odd pointer values test the bit-0 masking.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } rrf_state_e;

  localparam int FIELD_W  = 16;
  localparam int N_FIELDS = 4;
endpackage

// File: rtl/rrf_pend_ctr.sv
module rrf_pend_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_a,
  input  logic             add_b,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             nonzero
);
  localparam int          EXT_W   = CNT_W + 2;
  localparam logic [EXT_W-1:0] CNT_MAX = EXT_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] sum;

  always_comb begin
    sum = EXT_W'(cnt_q) + EXT_W'(add_a) + EXT_W'(add_b) - EXT_W'(take);
    if (sum > CNT_MAX) cnt_d = CNT_MAX[CNT_W-1:0];
    else               cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);

  // R10: queued requests must never be lost to saturation
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX[CNT_W-1:0] && !take) |-> !(add_a || add_b));
endmodule

// File: rtl/rrf_lane_pick.sv
module rrf_lane_pick #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16
) (
  input  logic               wide,
  input  logic               big_endian,
  input  logic [DATA_W-1:0]  data,
  output logic [FIELD_W-1:0] field
);
  localparam int HI_LSB = DATA_W - FIELD_W;

  always_comb begin
    if (wide && big_endian) field = data[DATA_W-1:HI_LSB];
    else                    field = data[FIELD_W-1:0];
  end
endmodule

// File: rtl/rrf_ptr_step.sv
module rrf_ptr_step #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] cur,
  input  logic             wide,
  input  logic [PTR_W-1:0] ring_start,
  input  logic [PTR_W-1:0] ring_end,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] next,
  output logic             hit_wr
);
  localparam logic [PTR_W-1:0] STEP_NARROW = PTR_W'(8);
  localparam logic [PTR_W-1:0] STEP_WIDE   = PTR_W'(16);

  logic [PTR_W-1:0] raw;

  always_comb begin
    raw    = cur + (wide ? STEP_WIDE : STEP_NARROW);
    next   = (raw == ring_end) ? ring_start : raw;
    hit_wr = (next == wr_ptr);
  end
endmodule

// File: rtl/rrf_ring_fetch.sv
module rrf_ring_fetch #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 32,
  parameter int PEND_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wide,
  input  logic                    cfg_big_endian,
  input  logic [ADDR_W-PTR_W-1:0] cfg_upper,
  input  logic [PTR_W-1:0]        cfg_ring_start,
  input  logic [PTR_W-1:0]        cfg_ring_end,
  input  logic [PTR_W-1:0]        cfg_wr_ptr,
  input  logic                    rd_load,
  input  logic [PTR_W-1:0]        rd_load_val,
  input  logic                    fetch_cmd,
  input  logic                    exh_clr,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    busy,
  output logic [PTR_W-1:0]        rd_ptr,
  output logic [2*rrf_pkg::FIELD_W-1:0] buf_base,
  output logic [2*rrf_pkg::FIELD_W-1:0] buf_words,
  output logic                    exhausted
);
  import rrf_pkg::*;

  localparam int IDX_W   = $clog2(N_FIELDS);
  localparam int N_HELD  = N_FIELDS - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FIELDS - 1);

  rrf_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             exh_q, exh_d;
  logic [2*FIELD_W-1:0] base_q, base_d, words_q, words_d;
  logic [FIELD_W-1:0]   held_q [N_HELD];

  logic [PTR_W-1:0] start_m, end_m, wr_m, load_m;
  logic [PTR_W-1:0] ptr_next, slot_off;
  logic             hit_wr;
  logic [FIELD_W-1:0] field_now;
  logic [PEND_W-1:0]  pend_cnt;
  logic             pend_nz, take, beat, complete, clear_hit;

  assign start_m = {cfg_ring_start[PTR_W-1:1], 1'b0};
  assign end_m   = {cfg_ring_end[PTR_W-1:1], 1'b0};
  assign wr_m    = {cfg_wr_ptr[PTR_W-1:1], 1'b0};
  assign load_m  = {rd_load_val[PTR_W-1:1], 1'b0};

  assign beat      = (state_q == ST_WAIT) && mem_rvalid;
  assign complete  = beat && (idx_q == LAST_IDX);
  assign take      = (state_q == ST_IDLE) && pend_nz;
  assign clear_hit = exh_clr && exh_q;

  rrf_pend_ctr #(.CNT_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .add_a(fetch_cmd), .add_b(clear_hit), .take(take),
    .count(pend_cnt), .nonzero(pend_nz)
  );

  rrf_lane_pick #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_lane (
    .wide(cfg_wide), .big_endian(cfg_big_endian),
    .data(mem_rdata), .field(field_now)
  );

  rrf_ptr_step #(.PTR_W(PTR_W)) u_step (
    .cur(ptr_q), .wide(cfg_wide),
    .ring_start(start_m), .ring_end(end_m), .wr_ptr(wr_m),
    .next(ptr_next), .hit_wr(hit_wr)
  );

  // field capture registers, one per held field
  for (genvar g = 0; g < N_HELD; g++) begin : g_held
    logic cap_en;
    assign cap_en = beat && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q[g] <= '0;
      else if (cap_en) held_q[g] <= field_now;
    end
  end

  assign slot_off = cfg_wide ? PTR_W'({idx_q, 2'b00}) : PTR_W'({idx_q, 1'b0});
  assign mem_req  = (state_q == ST_REQ);
  assign mem_addr = {cfg_upper, ptr_q + slot_off};

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (pend_nz) begin state_d = ST_REQ; idx_d = '0; end
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        if (idx_q == LAST_IDX) state_d = ST_IDLE;
        else begin state_d = ST_REQ; idx_d = idx_q + 1'b1; end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ptr_d   = ptr_q;
    base_d  = base_q;
    words_d = words_q;
    exh_d   = exh_q;
    if (clear_hit) exh_d = 1'b0;
    if (complete) begin
      ptr_d   = ptr_next;
      base_d  = {held_q[1], held_q[0]};
      words_d = {field_now, held_q[2]};
      if (hit_wr) exh_d = 1'b1;
    end
    if (rd_load) ptr_d = load_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      exh_q   <= 1'b0;
      base_q  <= '0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      exh_q   <= exh_d;
      base_q  <= base_d;
      words_q <= words_d;
    end
  end

  assign busy      = pend_nz || (state_q != ST_IDLE);
  assign rd_ptr    = ptr_q;
  assign buf_base  = base_q;
  assign buf_words = words_q;
  assign exhausted = exh_q;

  // R2: one read in flight; the request lasts a single cycle
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R2: no new request while waiting for data
  p_wait_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !mem_rvalid) |=> !mem_req);
  // R6: landing on the ring end reloads the start
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !rd_load &&
     (ptr_q + (cfg_wide ? PTR_W'(16) : PTR_W'(8))) == end_m)
    |=> (ptr_q == $past(start_m)));
  // R7: catching the write pointer raises the flag
  p_exh_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && hit_wr) |=> exh_q);
  // R8: a clear of a set flag drops it and leaves work queued
  p_clear_refetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_hit && !complete) |=> (!exh_q && busy));
  // R10: nothing queued or started leaves busy low
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !pend_nz && !fetch_cmd && !clear_hit) |=> !busy);
endmodule

// File: tb/rrf_ring_fetch_test.sv
`timescale 1ns/100ps
module rrf_ring_fetch_test;
  logic        clk, rst_n;
  logic        cfg_wide, cfg_big_endian;
  logic [15:0] cfg_upper, cfg_ring_start, cfg_ring_end, cfg_wr_ptr;
  logic        rd_load;
  logic [15:0] rd_load_val;
  logic        fetch_cmd, exh_clr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy;
  logic [15:0] rd_ptr;
  logic [31:0] buf_base, buf_words;
  logic        exhausted;

  rrf_ring_fetch uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wide(cfg_wide), .cfg_big_endian(cfg_big_endian),
    .cfg_upper(cfg_upper), .cfg_ring_start(cfg_ring_start),
    .cfg_ring_end(cfg_ring_end), .cfg_wr_ptr(cfg_wr_ptr),
    .rd_load(rd_load), .rd_load_val(rd_load_val),
    .fetch_cmd(fetch_cmd), .exh_clr(exh_clr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .rd_ptr(rd_ptr), .buf_base(buf_base),
    .buf_words(buf_words), .exhausted(exhausted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int lat = 1, cd = 0;
  logic [31:0] pend_addr;
  logic        prev_req = 1'b0;

  // reference model state
  logic [15:0] m_ptr;
  logic [31:0] m_base, m_words;
  logic        m_exh;
  int          m_out, m_beat;
  logic [15:0] m_f [4];

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[15:0] ^ 16'hC300, a[15:0] + 16'h1111};
  endfunction

  function automatic logic [15:0] msk(logic [15:0] v);
    return {v[15:1], 1'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // apply one clock: inputs already driven; model follows the edge
  task automatic cyc();
    logic [15:0] fld, raw;
    logic        done;
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000", cycles);
      finish_run();
    end
    mem_rvalid = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin mem_rvalid = 1'b1; mem_rdata = memf(pend_addr); end
    end
    if (mem_req) begin
      // R2 address order and slot size; R9 masked pointer
      chk("R2 mem_addr", mem_addr,
          {cfg_upper, m_ptr + 16'(m_beat * (cfg_wide ? 4 : 2))});
      chk("R2 no back-to-back req", {31'd0, prev_req}, 32'd0);
      pend_addr = mem_addr;
      cd = lat;
    end
    prev_req = mem_req;
    @(posedge clk);
    done = 1'b0;
    if (fetch_cmd) m_out++;
    if (exh_clr && m_exh) begin m_exh = 1'b0; m_out++; end
    if (mem_rvalid) begin
      fld = (cfg_wide && cfg_big_endian) ? mem_rdata[31:16] : mem_rdata[15:0];
      m_f[m_beat] = fld;
      if (m_beat == 3) begin done = 1'b1; m_beat = 0; end
      else m_beat++;
    end
    if (done) begin
      m_out--;
      m_base  = {m_f[1], m_f[0]};
      m_words = {m_f[3], m_f[2]};
      raw = m_ptr + (cfg_wide ? 16'd16 : 16'd8);
      m_ptr = (raw == msk(cfg_ring_end)) ? msk(cfg_ring_start) : raw;
      if (m_ptr == msk(cfg_wr_ptr)) m_exh = 1'b1;
    end
    if (rd_load) m_ptr = msk(rd_load_val);
    @(negedge clk);
    fetch_cmd = 1'b0; exh_clr = 1'b0; rd_load = 1'b0;
    chk("R5/R6 rd_ptr", {16'd0, rd_ptr}, {16'd0, m_ptr});
    chk("R3/R4 buf_base", buf_base, m_base);
    chk("R3/R4 buf_words", buf_words, m_words);
    chk("R7/R8 exhausted", {31'd0, exhausted}, {31'd0, m_exh});
    chk("R10 busy", {31'd0, busy}, {31'd0, (m_out > 0)});
  endtask

  task automatic run_idle();
    int n = 0;
    cyc();
    while (m_out > 0 && n < 500) begin cyc(); n++; end
    cyc();
  endtask

  task automatic load_ptr(logic [15:0] v);
    rd_load = 1'b1; rd_load_val = v; cyc();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wide = 0; cfg_big_endian = 0; cfg_upper = 16'h0012;
    cfg_ring_start = 16'h0100; cfg_ring_end = 16'h0118; cfg_wr_ptr = 16'h0110;
    rd_load = 0; rd_load_val = 0; fetch_cmd = 0; exh_clr = 0;
    mem_rvalid = 0; mem_rdata = 0;
    m_ptr = 0; m_base = 0; m_words = 0; m_exh = 0; m_out = 0; m_beat = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 rd_ptr", {16'd0, rd_ptr}, 32'd0);
    chk("R1 buf_base", buf_base, 32'd0);
    chk("R1 buf_words", buf_words, 32'd0);
    chk("R1 exhausted", {31'd0, exhausted}, 32'd0);
    chk("R1 busy/mem_req", {30'd0, busy, mem_req}, 32'd0);
    rst_n = 1'b1;
    cyc();

    // narrow little-endian: step 8, exhaustion then wrap
    load_ptr(16'h0100);
    fetch_cmd = 1'b1; run_idle();               // R3 R5 -> 0x108
    lat = 3;
    fetch_cmd = 1'b1; run_idle();               // R7 -> 0x110 == wr
    chk("R7 flag set", {31'd0, exhausted}, 32'd1);
    exh_clr = 1'b1; run_idle();                 // R8 refetch, R6 wrap
    chk("R6 wrapped to start", {16'd0, rd_ptr}, 32'h0100);
    chk("R8 flag cleared", {31'd0, exhausted}, 32'd0);

    // R8: clear while not set has no effect
    exh_clr = 1'b1; cyc();
    chk("R8 no refetch busy", {31'd0, busy}, 32'd0);
    repeat (4) begin
      chk("R8 no mem_req", {31'd0, mem_req}, 32'd0);
      cyc();
    end

    // R10: three requests queued during activity, serviced in order
    cfg_wr_ptr = 16'h0000; cfg_ring_end = 16'h0140; lat = 2;
    fetch_cmd = 1'b1; cyc();
    fetch_cmd = 1'b1; cyc();
    cyc();
    fetch_cmd = 1'b1; run_idle();
    chk("R10 three entries consumed", {16'd0, rd_ptr}, 32'h0118);

    // wide little-endian with odd pointers (R9), step 16
    cfg_wide = 1; cfg_upper = 16'h00A7;
    cfg_ring_start = 16'h0201; cfg_ring_end = 16'h0231; cfg_wr_ptr = 16'h0221;
    load_ptr(16'h0211);
    chk("R9 loaded pointer masked", {16'd0, rd_ptr}, 32'h0210);
    lat = 1;
    fetch_cmd = 1'b1; run_idle();
    chk("R9/R7 wide hits masked wr", {31'd0, exhausted}, 32'd1);
    exh_clr = 1'b1; run_idle();
    chk("R6/R9 wide wrap to masked start", {16'd0, rd_ptr}, 32'h0200);

    // wide big-endian: upper lane
    cfg_big_endian = 1; lat = 2;
    fetch_cmd = 1'b1; run_idle();
    chk("R4 big-endian lane", buf_base,
        {memf({16'h00A7, 16'h0204})[31:16], memf({16'h00A7, 16'h0200})[31:16]});
    fetch_cmd = 1'b1; run_idle();

    finish_run();
  end
endmodule